// File: doc/BRIEF.md
# Condition Register and Branch Unit

This unit settles compares and conditional branches for a 32-bit integer core. It keeps a 32-bit condition register made of eight 4-bit fields, a 32-bit loop count register, and a sticky overflow flag. Each 4-bit field holds four flags, in this order: less-than, greater-than, equal, and a copy of the sticky overflow flag.

Compares can be signed or unsigned. Each compares operand A with either operand B or a 16-bit immediate, and writes its result into any of the eight fields. A recorded ALU result always lands in field 0 and is compared, as a signed value, against zero.

Branch operations can test one condition bit for a required value, step the count register down and test whether it is zero, or do both at once. Each branch produces a registered taken flag and a PC-relative target. The pipeline issues at most one operation per cycle on `op_valid`. Overflowing arithmetic reports itself on `ovf_set`.

Top module: `cond_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cr_out`, `ctr_out`, `so_flag` and `taken` become 0 after that edge.
- R2: Signed compare (op 1) writes the field selected by `fld_sel`. For field f, LT sits at bit number 4f, GT at 4f+1, EQ at 4f+2 and SO at 4f+3, where bit number b is `cr_out[31-b]`. Exactly one of LT, GT, EQ is set. The other seven fields are unchanged.
- R3: Unsigned compare (op 2) writes the selected field in the same way, ordering the operands as unsigned numbers.
- R4: With `use_imm` high, the second operand is `imm`. It is sign-extended for op 1 and zero-extended for op 2.
- R5: Record (op 3) writes field 0 with a signed compare of `opa` against zero, whatever the value of `fld_sel`.
- R6: `ovf_set` sets the sticky flag `so_flag`. Op 11 clears it, and `ovf_set` wins over the clear in the same cycle. The SO bit written by ops 1 to 3 equals `so_flag | ovf_set`.
- R7: Op 4 is always taken. Op 5 is taken when condition bit number `bit_sel` equals `bit_want`.
- R8: Ops 6 and 7 decrement `ctr_out` by 1, with wrap-around from 0. Op 6 is taken when the new count is nonzero. Op 7 is taken when the new count is zero.
- R9: Ops 8 and 9 are taken only when the count condition of op 6 or op 7 (respectively) holds and condition bit `bit_sel` equals `bit_want`. Both still decrement the count.
- R10: Ops 4 to 11 leave `cr_out` unchanged. Only ops 6 to 10 change `ctr_out`.
- R11: Op 10 loads `ctr_out` from `opa`.
- R12: After a branch op (4 to 9), `target` is `pc` plus the sign-extended `br_offs`, and `taken` shows the decision. After any other cycle, `taken` is 0 and `target` holds its value.
- R13: When `op_valid` is low, only `ovf_set` may change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation: 0 none, 1 signed compare, 2 unsigned compare, 3 record, 4 always branch, 5 bit branch, 6 decrement/nonzero, 7 decrement/zero, 8 decrement/nonzero and bit, 9 decrement/zero and bit, 10 load count, 11 clear sticky overflow |
| fld_sel | input | 3 | Destination field for compares |
| bit_sel | input | 5 | Condition bit number tested by branches |
| bit_want | input | 1 | Required value of the tested bit |
| use_imm | input | 1 | Compare against the immediate instead of `opb` |
| opa | input | 32 | First compare operand, ALU result, or count load value |
| opb | input | 32 | Second register compare operand |
| imm | input | 16 | Compare immediate |
| ovf_set | input | 1 | Arithmetic overflow occurred this cycle |
| pc | input | 32 | Address of the branch |
| br_offs | input | 16 | Signed branch displacement |
| taken | output | 1 | Branch decision of the previous operation |
| target | output | 32 | Branch target of the last branch |
| cr_out | output | 32 | Condition register |
| ctr_out | output | 32 | Count register |
| so_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach from the ports are the edges of the count register. A decrement from exactly 1 must turn a nonzero-test branch into not-taken. A decrement from 0 must wrap to all ones and count as nonzero. Random 32-bit loads almost never produce these values, so directed sequences load the count with 1 and 0 through op 10 before branching. The random phase draws count loads from a small range so that loops run down to zero often. Compare operands are biased towards equal values and towards the boundary where the sign-extended and zero-extended immediate disagree, so that EQ and the signed/unsigned split are both hit.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    parameter int XLEN  = 32;
    parameter int NFLD  = 8;
    parameter int FLDW  = 4;
    parameter int IMMW  = 16;
    parameter int OFFW  = 16;
    localparam int CRW   = NFLD * FLDW;
    localparam int FSELW = $clog2(NFLD);
    localparam int BSELW = $clog2(CRW);

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_CMPS   = 4'd1,
        OP_CMPU   = 4'd2,
        OP_REC    = 4'd3,
        OP_BALW   = 4'd4,
        OP_BBIT   = 4'd5,
        OP_BDNZ   = 4'd6,
        OP_BDZ    = 4'd7,
        OP_BDNZB  = 4'd8,
        OP_BDZB   = 4'd9,
        OP_LDCTR  = 4'd10,
        OP_CLRSO  = 4'd11
    } op_e;

    // field layout: most significant bit of the field is the lowest bit number
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

    function automatic logic is_branch(input op_e op);
        return (op == OP_BALW) || (op == OP_BBIT) || (op == OP_BDNZ) ||
               (op == OP_BDZ) || (op == OP_BDNZB) || (op == OP_BDZB);
    endfunction

    function automatic logic uses_ctr(input op_e op);
        return (op == OP_BDNZ) || (op == OP_BDZ) || (op == OP_BDNZB) || (op == OP_BDZB);
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){1'b0}}, v};
    endfunction

    function automatic crf_t order_fld(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                       input logic sgn, input logic so);
        crf_t r;
        logic less;
        less = sgn ? ($signed(a) < $signed(b)) : (a < b);
        r.eq = (a == b);
        r.lt = less;
        r.gt = !less && (a != b);
        r.so = so;
        return r;
    endfunction
endpackage

// File: rtl/cbu_compare.sv
module cbu_compare
    import cbu_pkg::*;
(
    input  op_e             op,
    input  logic            use_imm,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [IMMW-1:0] imm,
    input  logic            so_in,
    output crf_t            res
);
    logic            sgn;
    logic [XLEN-1:0] rhs;

    always_comb begin
        sgn = (op != OP_CMPU);
        if (op == OP_REC)
            rhs = '0;
        else if (use_imm)
            rhs = (op == OP_CMPS) ? sext_imm(imm) : zext_imm(imm);
        else
            rhs = opb;
        res = order_fld(opa, rhs, sgn, so_in);
    end
endmodule

// File: rtl/cbu_cr_file.sv
module cbu_cr_file
    import cbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [FSELW-1:0] wr_fsel,
    input  crf_t             wr_val,
    output logic [CRW-1:0]   cr_q
);
    logic [NFLD-1:0] fld_we;

    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        assign fld_we[i] = wr_en && (wr_fsel == FSELW'(i));

        always_ff @(posedge clk) begin
            if (rst)
                cr_q[CRW-1-FLDW*i -: FLDW] <= '0;
            else if (fld_we[i])
                cr_q[CRW-1-FLDW*i -: FLDW] <= wr_val;
        end

        // R2: a written field carries exactly one ordering flag
        a_r2_one_order: assert property (@(posedge clk) disable iff (rst)
            fld_we[i] |=> $countones(cr_q[CRW-1-FLDW*i -: 3]) == 1);

        // R2: fields not selected keep their value
        a_r2_others_hold: assert property (@(posedge clk) disable iff (rst)
            !fld_we[i] |=> $stable(cr_q[CRW-1-FLDW*i -: FLDW]));
    end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
(
    input  op_e              op,
    input  logic [CRW-1:0]   cr_q,
    input  logic [BSELW-1:0] bit_sel,
    input  logic             bit_want,
    input  logic [XLEN-1:0]  ctr_q,
    output logic             take,
    output logic [XLEN-1:0]  ctr_dec
);
    logic [BSELW-1:0] bidx;
    logic             bit_ok;
    logic             nz;

    always_comb begin
        bidx    = BSELW'(CRW-1) - bit_sel;
        bit_ok  = (cr_q[bidx] == bit_want);
        ctr_dec = ctr_q - XLEN'(1);
        nz      = (ctr_dec != '0);
        unique case (op)
            OP_BALW:  take = 1'b1;
            OP_BBIT:  take = bit_ok;
            OP_BDNZ:  take = nz;
            OP_BDZ:   take = !nz;
            OP_BDNZB: take = nz && bit_ok;
            OP_BDZB:  take = !nz && bit_ok;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
    import cbu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [2:0]  fld_sel,
    input  logic [4:0]  bit_sel,
    input  logic        bit_want,
    input  logic        use_imm,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic [15:0] imm,
    input  logic        ovf_set,
    input  logic [31:0] pc,
    input  logic [15:0] br_offs,
    output logic        taken,
    output logic [31:0] target,
    output logic [31:0] cr_out,
    output logic [31:0] ctr_out,
    output logic        so_flag
);
    op_e              op;
    logic             so_q;
    logic             so_eff;
    logic [XLEN-1:0]  ctr_q;
    logic [XLEN-1:0]  ctr_dec;
    logic [CRW-1:0]   cr_q;
    crf_t             cmp_res;
    logic             cr_we;
    logic [FSELW-1:0] cr_fsel;
    logic             br_take;
    logic             taken_q;
    logic [XLEN-1:0]  target_q;
    logic             br_op;

    assign op      = op_valid ? op_e'(op_code) : OP_NONE;
    assign so_eff  = so_q | ovf_set;
    assign br_op   = is_branch(op);
    assign cr_we   = (op == OP_CMPS) || (op == OP_CMPU) || (op == OP_REC);
    assign cr_fsel = (op == OP_REC) ? '0 : FSELW'(fld_sel);

    cbu_compare u_cmp (
        .op      (op),
        .use_imm (use_imm),
        .opa     (opa),
        .opb     (opb),
        .imm     (imm),
        .so_in   (so_eff),
        .res     (cmp_res)
    );

    cbu_cr_file u_cr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cr_we),
        .wr_fsel (cr_fsel),
        .wr_val  (cmp_res),
        .cr_q    (cr_q)
    );

    cbu_cond_eval u_eval (
        .op       (op),
        .cr_q     (cr_q),
        .bit_sel  (BSELW'(bit_sel)),
        .bit_want (bit_want),
        .ctr_q    (ctr_q),
        .take     (br_take),
        .ctr_dec  (ctr_dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q    <= '0;
            so_q     <= 1'b0;
            taken_q  <= 1'b0;
            target_q <= '0;
        end else begin
            if (uses_ctr(op))
                ctr_q <= ctr_dec;
            else if (op == OP_LDCTR)
                ctr_q <= opa;
            so_q    <= ((op == OP_CLRSO) ? 1'b0 : so_q) | ovf_set;
            taken_q <= br_op && br_take;
            if (br_op)
                target_q <= pc + {{(XLEN-OFFW){br_offs[OFFW-1]}}, br_offs};
        end
    end

    assign taken   = taken_q;
    assign target  = target_q;
    assign cr_out  = cr_q;
    assign ctr_out = ctr_q;
    assign so_flag = so_q;

    // R8: count branches step the count down by one
    a_r8_ctr_step: assert property (@(posedge clk) disable iff (rst)
        uses_ctr(op) |=> ctr_out == $past(ctr_out) - 32'd1);

    // R10: branches leave the condition register alone
    a_r10_cr_hold: assert property (@(posedge clk) disable iff (rst)
        br_op |=> $stable(cr_out));

    // R6: overflow always leaves the sticky flag set
    a_r6_so_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> so_flag);

    // R12: taken only follows a branch operation
    a_r12_taken_src: assert property (@(posedge clk) disable iff (rst)
        !br_op |=> !taken);

    // R13: an idle cycle without overflow changes nothing
    a_r13_idle: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !ovf_set) |=> ($stable(ctr_out) && $stable(so_flag) && $stable(cr_out)));
endmodule

// File: tb/tb_cond_branch_unit.sv
module tb_cond_branch_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [2:0]  fld_sel = '0;
    logic [4:0]  bit_sel = '0;
    logic        bit_want = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] opa = '0, opb = '0, pc = '0;
    logic [15:0] imm = '0, br_offs = '0;
    logic        ovf_set = 1'b0;
    logic        taken, so_flag;
    logic [31:0] target, cr_out, ctr_out;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    logic [31:0] m_cr = '0, m_ctr = '0, m_tgt = '0;
    logic        m_so = 1'b0, m_tk = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cond_branch_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .fld_sel(fld_sel), .bit_sel(bit_sel), .bit_want(bit_want),
        .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm),
        .ovf_set(ovf_set), .pc(pc), .br_offs(br_offs),
        .taken(taken), .target(target), .cr_out(cr_out),
        .ctr_out(ctr_out), .so_flag(so_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_fld(input logic [31:0] a, input logic [31:0] b,
                                           input logic sgn, input logic so);
        logic l, g, e;
        e = (a == b);
        if (sgn) l = ($signed(a) < $signed(b)); else l = (a < b);
        g = !l && !e;
        return {l, g, e, so};
    endfunction

    function automatic string tag_of(input logic v, input int op);
        if (!v) return "R13 idle";
        case (op)
            1: return "R2/R4 signed compare";
            2: return "R3/R4 unsigned compare";
            3: return "R5 record";
            4: return "R7 always branch";
            5: return "R7 bit branch";
            6: return "R8 dec-nonzero";
            7: return "R8 dec-zero";
            8, 9: return "R9 combined branch";
            10: return "R11 load count";
            11: return "R6 clear sticky";
            default: return "R10 no-op";
        endcase
    endfunction

    task automatic do_op(input logic v, input int op, input int f, input int bs, input logic want,
                         input logic ui, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic ov, input logic [31:0] p,
                         input logic [15:0] ofs);
        logic [31:0] rhs;
        logic [3:0]  fv;
        logic        so_e, bitv, nz, isbr;
        int          eop;
        string       tg;
        op_valid = v; op_code = 4'(op); fld_sel = 3'(f); bit_sel = 5'(bs);
        bit_want = want; use_imm = ui; opa = a; opb = b; imm = im;
        ovf_set = ov; pc = p; br_offs = ofs;
        eop = v ? op : 0;
        tg = tag_of(v, op);
        so_e = m_so | ov;
        bitv = (m_cr[31-bs] == want);
        isbr = (eop >= 4 && eop <= 9);
        m_tk = 1'b0;
        case (eop)
            1, 2: begin
                if (ui) rhs = (eop == 1) ? {{16{im[15]}}, im} : {16'h0, im};
                else rhs = b;
                fv = ref_fld(a, rhs, eop == 1, so_e);
                for (int k = 0; k < 4; k++) m_cr[31-4*f-k] = fv[3-k];
            end
            3: begin
                fv = ref_fld(a, 32'h0, 1'b1, so_e);
                for (int k = 0; k < 4; k++) m_cr[31-k] = fv[3-k];
            end
            4: m_tk = 1'b1;
            5: m_tk = bitv;
            6, 7, 8, 9: begin
                m_ctr = m_ctr - 32'd1;
                nz = (m_ctr != 0);
                if (eop == 6) m_tk = nz;
                else if (eop == 7) m_tk = !nz;
                else if (eop == 8) m_tk = nz && bitv;
                else m_tk = !nz && bitv;
            end
            10: m_ctr = a;
            default: ;
        endcase
        if (isbr) m_tgt = p + {{16{ofs[15]}}, ofs};
        m_so = ((eop == 11) ? 1'b0 : m_so) | ov;
        @(posedge clk);
        #1;
        chk({tg, " cr (R10)"}, cr_out, m_cr);
        chk({tg, " ctr (R10)"}, ctr_out, m_ctr);
        chk({tg, " so (R6)"}, {31'b0, so_flag}, {31'b0, m_so});
        chk({tg, " taken (R12)"}, {31'b0, taken}, {31'b0, m_tk});
        chk({tg, " target (R12)"}, target, m_tgt);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 cr", cr_out, 0);
        chk("R1 ctr", ctr_out, 0);
        chk("R1 so", {31'b0, so_flag}, 0);
        chk("R1 taken", {31'b0, taken}, 0);
        @(negedge clk);

        // R4: immediate 0x8000 against 0xFFFF8000: signed equal, unsigned greater
        do_op(1, 1, 2, 0, 0, 1, 32'hFFFF_8000, 0, 16'h8000, 0, 0, 0);
        do_op(1, 2, 5, 0, 0, 1, 32'hFFFF_8000, 0, 16'h8000, 0, 0, 0);
        // R3 register operands: negative is large unsigned
        do_op(1, 2, 7, 0, 0, 0, 32'h8000_0000, 32'h1, 0, 0, 0, 0);
        // R6: overflow then record copies SO, clear, set wins over clear
        do_op(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        do_op(1, 3, 6, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        do_op(1, 11, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        do_op(1, 11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op(1, 1, 0, 0, 0, 0, 5, 5, 0, 1, 0, 0);
        // R8: count of 1 then dec-nonzero not taken, dec-zero from 1 taken
        do_op(1, 10, 0, 0, 0, 0, 32'd1, 0, 0, 0, 0, 0);
        do_op(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 32'h100, 16'hFFF0);
        do_op(1, 10, 0, 0, 0, 0, 32'd1, 0, 0, 0, 0, 0);
        do_op(1, 7, 0, 0, 0, 0, 0, 0, 0, 0, 32'h200, 16'h0010);
        // R8 wrap from zero is nonzero
        do_op(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 32'h300, 16'h0004);
        // R9 combined with bit true and false
        do_op(1, 10, 0, 0, 0, 0, 32'd3, 0, 0, 0, 0, 0);
        do_op(1, 8, 0, 2, 1, 0, 0, 0, 0, 0, 32'h400, 16'h8000);
        do_op(1, 8, 0, 2, 0, 0, 0, 0, 0, 0, 32'h400, 16'h8000);
        do_op(1, 9, 0, 2, 1, 0, 0, 0, 0, 0, 32'h400, 16'h0008);
        // R7 bit branch and always branch
        do_op(1, 5, 0, 10, 1, 0, 0, 0, 0, 0, 32'h500, 16'h0020);
        do_op(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 32'h600, 16'hFFFC);
        // R13 invalid compare and invalid load are ignored
        do_op(0, 1, 3, 0, 0, 0, 1, 2, 0, 0, 0, 0);
        do_op(0, 10, 0, 0, 0, 0, 32'h55, 0, 0, 0, 0, 0);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            logic [15:0] im;
            int op;
            a = ($urandom_range(0, 2) == 0) ? $urandom() : 32'($signed($urandom_range(0, 8)) - 4);
            b = ($urandom_range(0, 2) == 0) ? a : (($urandom_range(0, 1) == 0) ? $urandom() : 32'($urandom_range(0, 4)) - 32'd2);
            im = ($urandom_range(0, 1) == 0) ? a[15:0] : 16'($urandom());
            op = $urandom_range(0, 11);
            if (op == 10) a = 32'($urandom_range(0, 4));
            do_op($urandom_range(0, 7) != 0, op, $urandom_range(0, 7), $urandom_range(0, 31),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, b, im,
                  $urandom_range(0, 15) == 0, $urandom(), 16'($urandom()));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule